// File: doc/BRIEF.md
# H-Bridge Switch Control

This block is the digital control core of a full-bridge motor driver. It turns two direction inputs, one PWM input and two per-leg enable pins into four registered gate enables: a high-side and a low-side enable for each of legs A and B. Leg A uses bit 0 of every two-bit vector and leg B uses bit 1. Each leg is decoded on its own. A direction input of 1 selects that leg's high side and a 0 selects its low side, so 11 brakes to supply, 00 brakes to ground, and 01 or 10 turns the motor one way or the other. Only the low sides are chopped by PWM.

When the direction inputs change, all four gates go off for a fixed blanking time counted in clocks, and only then is the new mode applied. This prevents a high side and a low side of one leg from conducting together. The supply-window flags turn the whole bridge off. A leg fault (high-side overtemperature or low-side saturation) latches that leg off and pulls its enable pin low through an open-drain output. The latch is released only by a fresh low-to-high edge on that leg's direction input while the fault is absent.

Each enable pin is modelled as a pin input, a drive value that is always 0, and an output enable. The pin input passes through a two-flop synchronizer before it is used.

Top module: `hbridge_ctrl`

## Requirements
- R1: In steady state, with its enable high, no latch and the supply in window, a leg's high-side gate equals its direction bit and its low-side gate equals the inverted direction bit ANDed with PWM. Bit 0 is leg A and bit 1 is leg B.
- R2: PWM low clears both low-side gates two clock edges after it is sampled. High-side gates are unaffected. PWM high restores the selected low sides after the same latency.
- R3: An enable pin held low turns off both gates of its leg three edges later, through the two-flop synchronizer and the output register. The other leg is unaffected.
- R4: A fault flag on a leg sets that leg's latch on the next edge. diag_oe for that leg goes to 1 with diag_drv at 0, and both gates of the leg are off from the following edge.
- R5: A latched leg is released only by a 0-to-1 change of its direction input that is sampled while neither of its fault flags is set. A rising edge during a fault, or a fault that simply clears, leaves the latch set.
- R6: supply_uv or supply_ov clears all four gates one edge later. Normal operation resumes one edge after both flags are low, and nothing is latched.
- R7: A change on dir_in clears all four gates from the second edge after it is sampled. They stay off for MODE_DELAY+1 outputs, and the new mode appears at the following edge.
- R8: The high-side and low-side gates of one leg are never both 1.
- R9: While reset is held and after it, all gates are 0, all latches are clear and diag_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_in | input | 2 | Direction bits; bit 0 leg A, bit 1 leg B |
| pwm_in | input | 1 | PWM for the low sides |
| en_pin_in | input | 2 | Sensed level of each enable/diagnostic pin |
| hs_overtemp | input | 2 | High-side overtemperature flag per leg |
| ls_sat | input | 2 | Low-side saturation flag per leg |
| supply_uv | input | 1 | Supply below window |
| supply_ov | input | 1 | Supply above window |
| gate_hs | output | 2 | High-side gate enable per leg |
| gate_ls | output | 2 | Low-side gate enable per leg |
| diag_drv | output | 2 | Value driven on each enable pin (always 0) |
| diag_oe | output | 2 | Output enable of each pin driver; 1 while the leg is latched |

## Verification
The hardest case to reach from the ports is the release rule. The bench must first latch a leg, then raise that leg's direction bit while the fault flag is still set, and confirm that the leg stays off. It then drops the direction bit, clears the fault, and raises the bit again. This is the only path that frees the leg. The bench also checks that a fault which simply goes away leaves the leg latched. Because the enable pin is looped back through diag_oe in the bench, the pin is held low during the latch and recovers through the synchronizer after release. Randomized steady-state settings of direction, PWM, enables and the supply flags are compared against a bench function of the R1 rule.

// File: rtl/hb_pkg.sv
package hb_pkg;
    localparam int NLEG = 2;

    typedef struct packed {
        logic hs;
        logic ls;
    } leg_gate_t;

    // Per-leg decode: direction 1 selects high side, 0 selects low side.
    function automatic leg_gate_t leg_decode(input logic dir, input logic pwm);
        leg_gate_t g;
        g.hs = dir;
        g.ls = ~dir & pwm;
        return g;
    endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hb_mode_timer.sv
module hb_mode_timer #(
    parameter int DELAY = 60,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] mode_req,
    output logic [W-1:0] mode_act,
    output logic         blank
);
    localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;

    logic [CW-1:0] cnt;
    logic          busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            busy     <= 1'b0;
            mode_act <= '0;
        end else if (!busy) begin
            if (mode_req != mode_act) begin
                busy <= 1'b1;
                cnt  <= CW'(DELAY - 1);
            end
        end else if (cnt == '0) begin
            busy     <= 1'b0;
            mode_act <= mode_req;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign blank = busy | (mode_req != mode_act);
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic fault,
    input  logic dir_rise,
    output logic latched
);
    always_ff @(posedge clk) begin
        if (rst)
            latched <= 1'b0;
        else if (fault)
            latched <= 1'b1;
        else if (latched && dir_rise)
            latched <= 1'b0;
    end
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hb_pkg::*;
#(
    parameter int MODE_DELAY = 60
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NLEG-1:0] dir_in,
    input  logic            pwm_in,
    input  logic [NLEG-1:0] en_pin_in,
    input  logic [NLEG-1:0] hs_overtemp,
    input  logic [NLEG-1:0] ls_sat,
    input  logic            supply_uv,
    input  logic            supply_ov,
    output logic [NLEG-1:0] gate_hs,
    output logic [NLEG-1:0] gate_ls,
    output logic [NLEG-1:0] diag_drv,
    output logic [NLEG-1:0] diag_oe
);
    logic [NLEG-1:0] mode_q, dir_prev, dir_rise;
    logic [NLEG-1:0] mode_act, en_s, latched;
    logic            pwm_q, blank, supply_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            dir_prev <= '0;
            pwm_q    <= 1'b0;
        end else begin
            mode_q   <= dir_in;
            dir_prev <= mode_q;
            pwm_q    <= pwm_in;
        end
    end

    assign dir_rise   = mode_q & ~dir_prev;
    assign supply_bad = supply_uv | supply_ov;

    hb_sync #(.W(NLEG)) u_en_sync (
        .clk(clk), .rst(rst), .d(en_pin_in), .q(en_s)
    );

    hb_mode_timer #(.DELAY(MODE_DELAY), .W(NLEG)) u_timer (
        .clk(clk), .rst(rst), .mode_req(mode_q),
        .mode_act(mode_act), .blank(blank)
    );

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        leg_gate_t dec;
        logic      allow;

        hb_fault_latch u_latch (
            .clk(clk), .rst(rst),
            .fault(hs_overtemp[g] | ls_sat[g]),
            .dir_rise(dir_rise[g]),
            .latched(latched[g])
        );

        assign dec   = leg_decode(mode_act[g], pwm_q);
        assign allow = en_s[g] & ~latched[g] & ~blank & ~supply_bad;

        always_ff @(posedge clk) begin
            if (rst) begin
                gate_hs[g] <= 1'b0;
                gate_ls[g] <= 1'b0;
            end else begin
                gate_hs[g] <= allow & dec.hs;
                gate_ls[g] <= allow & dec.ls;
            end
        end

        assign diag_oe[g]  = latched[g];
        assign diag_drv[g] = 1'b0;
    end
endmodule

// File: rtl/hb_ctrl_chk.sv
module hb_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] dir_in,
    input logic       pwm_in,
    input logic [1:0] en_pin_in,
    input logic [1:0] hs_overtemp,
    input logic [1:0] ls_sat,
    input logic       supply_uv,
    input logic       supply_ov,
    input logic [1:0] gate_hs,
    input logic [1:0] gate_ls,
    input logic [1:0] diag_drv,
    input logic [1:0] diag_oe
);
    for (genvar g = 0; g < 2; g++) begin : g_chk
        a_r8_no_shoot_through: assert property (@(posedge clk) disable iff (rst)
            !(gate_hs[g] && gate_ls[g]));
        a_r3_enable_low_off: assert property (@(posedge clk) disable iff (rst)
            !$past(en_pin_in[g], 3) |-> (!gate_hs[g] && !gate_ls[g]));
        a_r4_fault_latches: assert property (@(posedge clk) disable iff (rst)
            (hs_overtemp[g] || ls_sat[g]) |=> diag_oe[g]);
        a_r4_latched_off: assert property (@(posedge clk) disable iff (rst)
            $past(diag_oe[g]) |-> (!gate_hs[g] && !gate_ls[g]));
        a_r4_drive_low: assert property (@(posedge clk) disable iff (rst)
            diag_oe[g] |-> !diag_drv[g]);
        a_r5_release_clean: assert property (@(posedge clk) disable iff (rst)
            $fell(diag_oe[g]) |-> !$past(hs_overtemp[g] || ls_sat[g]));
    end

    a_r2_pwm_low_side: assert property (@(posedge clk) disable iff (rst)
        !$past(pwm_in, 2) |-> (gate_ls == 2'b00));
    a_r6_supply_off: assert property (@(posedge clk) disable iff (rst)
        (supply_uv || supply_ov) |=> (gate_hs == 2'b00 && gate_ls == 2'b00));
    a_r7_mode_blank: assert property (@(posedge clk) disable iff (rst)
        (dir_in != $past(dir_in)) |=> ##1 (gate_hs == 2'b00 && gate_ls == 2'b00));
endmodule

bind hbridge_ctrl hb_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .dir_in(dir_in), .pwm_in(pwm_in),
    .en_pin_in(en_pin_in), .hs_overtemp(hs_overtemp), .ls_sat(ls_sat),
    .supply_uv(supply_uv), .supply_ov(supply_ov), .gate_hs(gate_hs),
    .gate_ls(gate_ls), .diag_drv(diag_drv), .diag_oe(diag_oe)
);

// File: tb/sim_hbridge_ctrl.sv
module sim_hbridge_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 60;
    localparam int SETTLE     = DLY + 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] dir_in = 2'b00;
    logic       pwm_in = 1'b1;
    logic [1:0] ext_en = 2'b11;
    logic [1:0] en_pin;
    logic [1:0] hs_overtemp = 2'b00;
    logic [1:0] ls_sat = 2'b00;
    logic       supply_uv = 1'b0;
    logic       supply_ov = 1'b0;
    logic [1:0] gate_hs, gate_ls, diag_drv, diag_oe;

    int checks = 0;
    int errors = 0;

    // open-drain pin: external pull-up level, pulled low while the block drives it
    assign en_pin = ext_en & ~diag_oe;

    hbridge_ctrl #(.MODE_DELAY(DLY)) u0 (
        .clk(clk), .rst(rst), .dir_in(dir_in), .pwm_in(pwm_in),
        .en_pin_in(en_pin), .hs_overtemp(hs_overtemp), .ls_sat(ls_sat),
        .supply_uv(supply_uv), .supply_ov(supply_ov), .gate_hs(gate_hs),
        .gate_ls(gate_ls), .diag_drv(diag_drv), .diag_oe(diag_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // returns {gate_hs[1:0], gate_ls[1:0]}
    function automatic logic [3:0] exp_gates(input logic [1:0] dir, input logic pwm,
                                             input logic [1:0] en, input logic [1:0] lat,
                                             input logic sup);
        logic [1:0] hs, ls;
        for (int g = 0; g < 2; g++) begin
            hs[g] = dir[g] & en[g] & ~lat[g] & ~sup;
            ls[g] = ~dir[g] & pwm & en[g] & ~lat[g] & ~sup;
        end
        return {hs, ls};
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic steady(input string req, input logic [1:0] lat);
        chk(req, {gate_hs, gate_ls},
            exp_gates(dir_in, pwm_in, ext_en, lat, supply_uv | supply_ov));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R9 reset state
        edges(5);
        chk("R9 reset gates", {gate_hs, gate_ls}, 4'b0000);
        chk("R9 reset diag", {diag_oe, diag_drv}, 4'b0000);
        rst = 1'b0;
        edges(SETTLE);
        chk("R9 after reset diag", {2'b00, diag_oe}, 4'b0000);
        steady("R1 brake to ground", 2'b00);

        // R1 all four modes
        for (int m = 0; m < 4; m++) begin
            dir_in = 2'(m);
            edges(SETTLE);
            steady("R1 mode decode", 2'b00);
        end

        // R7 exact blanking window: 11 -> 01
        dir_in = 2'b01;
        edges(2);
        for (int i = 0; i <= DLY; i++) begin
            chk("R7 blank off", {gate_hs, gate_ls}, 4'b0000);
            edges(1);
        end
        chk("R7 new mode applied", {gate_hs, gate_ls}, 4'b0110);

        // R2 PWM chops only low sides
        pwm_in = 1'b0;
        edges(1);
        chk("R2 one edge still old", {gate_hs, gate_ls}, 4'b0110);
        edges(1);
        chk("R2 pwm low", {gate_hs, gate_ls}, 4'b0100);
        pwm_in = 1'b1;
        edges(2);
        chk("R2 pwm high restores", {gate_hs, gate_ls}, 4'b0110);

        // R3 enable pin low on leg B
        ext_en = 2'b01;
        edges(2);
        chk("R3 before sync latency", {gate_hs, gate_ls}, 4'b0110);
        edges(1);
        chk("R3 leg B off, A kept", {gate_hs, gate_ls}, 4'b0100);
        ext_en = 2'b11;
        edges(4);
        chk("R3 leg B back", {gate_hs, gate_ls}, 4'b0110);

        // R6 supply window
        supply_uv = 1'b1;
        edges(1);
        chk("R6 undervoltage off", {gate_hs, gate_ls}, 4'b0000);
        supply_uv = 1'b0;
        edges(1);
        chk("R6 resumes", {gate_hs, gate_ls}, 4'b0110);
        supply_ov = 1'b1;
        edges(1);
        chk("R6 overvoltage off", {gate_hs, gate_ls}, 4'b0000);
        supply_ov = 1'b0;
        edges(1);
        chk("R6 resumes no latch", {gate_hs, gate_ls, diag_oe}, 6'b011000);

        // R4 fault on leg A
        dir_in = 2'b11;
        edges(SETTLE);
        hs_overtemp = 2'b01;
        edges(1);
        hs_overtemp = 2'b00;
        chk("R4 latch sets", {2'b00, diag_oe, diag_drv}, 6'b000100);
        edges(1);
        chk("R4 leg A off", {gate_hs, gate_ls}, 4'b1000);
        edges(SETTLE);
        chk("R5 fault gone still latched", {gate_hs, gate_ls, diag_oe}, 6'b100001);

        // R5 rising edge during active fault does not release
        ls_sat = 2'b01;
        dir_in = 2'b10;
        edges(SETTLE);
        dir_in = 2'b11;
        edges(SETTLE);
        chk("R5 rise during fault held", {gate_hs, gate_ls, diag_oe}, 6'b100001);
        ls_sat = 2'b00;
        dir_in = 2'b10;
        edges(SETTLE);
        chk("R5 fall does not release", {2'b00, diag_oe}, 4'b0001);
        dir_in = 2'b11;
        edges(SETTLE);
        chk("R5 clean rise releases", {gate_hs, gate_ls, diag_oe}, 6'b110000);

        // R4/R5 leg B via low-side saturation
        dir_in = 2'b00;
        edges(SETTLE);
        ls_sat = 2'b10;
        edges(2);
        ls_sat = 2'b00;
        chk("R4 leg B latched", {gate_hs, gate_ls, diag_oe}, 6'b000110);
        dir_in = 2'b10;
        edges(SETTLE);
        chk("R5 leg B released by rise", {gate_hs, gate_ls, diag_oe}, 6'b100100);

        // random steady-state
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < 150; i++) begin
            dir_in    = 2'($urandom_range(0, 3));
            pwm_in    = 1'($urandom_range(0, 1));
            ext_en    = 2'($urandom_range(0, 3));
            supply_uv = ($urandom_range(0, 7) == 0);
            supply_ov = ($urandom_range(0, 7) == 0);
            edges(SETTLE);
            steady("R1 R2 R3 R6 random", 2'b00);
            chk("R8 no same-leg overlap", {2'b00, gate_hs & gate_ls}, 4'b0000);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule